// File: doc/BRIEF.md
# Conditional Execution Block Sequencer

This block sits beside an instruction issue stage and governs short runs of predicated instructions. A 16-bit prefix instruction opens a run of one to four instructions. Its low nibble is a pattern mask and the next nibble is a base condition code. After the prefix, the block produces, for every instruction issued, the 4-bit condition that applies to it. It also reports whether that condition holds against the current N, Z, C and V flags, so the issue stage can squash instructions whose condition fails.

Each slot's condition is derived from the base code. Its least significant bit is replaced by a bit taken from a mask that shifts left once per issued instruction. The run ends by itself when the shifted mask reaches a sentinel value, so no instruction counter is kept. Outside a run, every instruction is allowed. The allow output is combinational from the stored state and the flags. The state moves only on a clock edge, when a load or an advance strobe is high.

Top module: `cond_block_seq`

## Requirements
- R1: After a synchronous active-high reset, the block is idle: `in_blk_o`=0, `allow_o`=1 and `cond_o`=4'd14 (AL).
- R2: A load with a nonzero mask in `instr_i[3:0]` starts a run. From the next cycle, `in_blk_o`=1 and the base condition is `instr_i[7:4]`. Bits 15:8 have no effect.
- R3: A load whose `instr_i[3:0]` is zero is a no-op hint. It leaves the block idle, and it also ends any run in progress.
- R4: The first instruction of a run uses the base condition unchanged.
- R5: Every later instruction uses the base condition with bit 0 replaced by the mask bit that has moved into position 3. The first later slot takes original mask bit 3, the next takes bit 2, then bit 1.
- R6: The run length is set by the lowest set bit of the mask: bit 3 gives 1 instruction, bit 2 gives 2, bit 1 gives 3, and bit 0 gives 4. After the last advance of a run the block is idle.
- R7: When idle, `allow_o`=1 and `cond_o`=AL whatever the flags, and an advance strobe has no effect.
- R8: Conditions are evaluated with the codes 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V) and 14 AL (true).
- R9: Condition code 15 evaluates to false.
- R10: When a load and an advance arrive in the same cycle, the load wins and the advance is discarded.
- R11: With no load and no advance, the state holds. `cond_o` and `in_blk_o` stay unchanged, and only `allow_o` follows the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load strobe for the prefix instruction |
| instr_i | input | 16 | Prefix instruction word: [7:4] base condition, [3:0] mask |
| adv_i | input | 1 | One pulse per instruction issued after the prefix |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| allow_o | output | 1 | Current instruction may execute |
| in_blk_o | output | 1 | A run is in progress |
| cond_o | output | 4 | Effective condition for the current slot (AL when idle) |

## Verification
The bench drives every one of the 15 nonzero masks, so that run lengths of 1 to 4 and every then/else pattern appear. A sentinel test taken before the shift, or a missed shift of the mask, would show up there as a run one slot too long or too short, or as a flipped condition bit. Every condition code is checked against all 16 flag combinations. This catches swapped signed comparisons and a code 15 that wrongly passes. Further tests cover a zero-mask hint that arrives in the middle of a run, a load and an advance in the same cycle, and advances while idle. A design that started a run on a hint, took the advance in place of the load, or moved state while idle would then produce the wrong condition on the next slot.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int CC_W   = 4;
    localparam int MASK_W = 4;

    typedef enum logic [CC_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [CC_W-1:0]   base;
        logic              first;
    } seq_st_t;

endpackage

// File: rtl/cbs_cond_eval.sv
module cbs_cond_eval
    import cbs_pkg::*;
(
    input  cc_e    cc_i,
    input  flags_t fl_i,
    output logic   pass_o
);

    logic sign_ok;

    always_comb begin
        sign_ok = (fl_i.n == fl_i.v);
        unique case (cc_i)
            CC_EQ:   pass_o =  fl_i.z;
            CC_NE:   pass_o = !fl_i.z;
            CC_CS:   pass_o =  fl_i.c;
            CC_CC:   pass_o = !fl_i.c;
            CC_MI:   pass_o =  fl_i.n;
            CC_PL:   pass_o = !fl_i.n;
            CC_VS:   pass_o =  fl_i.v;
            CC_VC:   pass_o = !fl_i.v;
            CC_HI:   pass_o =  fl_i.c && !fl_i.z;
            CC_LS:   pass_o = !fl_i.c ||  fl_i.z;
            CC_GE:   pass_o =  sign_ok;
            CC_LT:   pass_o = !sign_ok;
            CC_GT:   pass_o = !fl_i.z &&  sign_ok;
            CC_LE:   pass_o =  fl_i.z || !sign_ok;
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbs_slot_ctl.sv
module cbs_slot_ctl
    import cbs_pkg::*;
(
    input  seq_st_t           st_i,
    output cc_e               eff_o,
    output logic [MASK_W-1:0] mask_nx_o
);

    localparam logic [MASK_W-1:0] SENTINEL = {1'b1, {(MASK_W-1){1'b0}}};

    logic [MASK_W-1:0] shifted;

    always_comb begin
        if (st_i.first) begin
            eff_o   = cc_e'(st_i.base);
            shifted = st_i.mask;
        end else begin
            eff_o   = cc_e'({st_i.base[CC_W-1:1], st_i.mask[MASK_W-1]});
            shifted = {st_i.mask[MASK_W-2:0], 1'b0};
        end
        mask_nx_o = (shifted == SENTINEL) ? '0 : shifted;
    end

endmodule

// File: rtl/cond_block_seq.sv
module cond_block_seq
    import cbs_pkg::*;
#(
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               adv_i,
    input  logic               flag_n_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    input  logic               flag_v_i,
    output logic               allow_o,
    output logic               in_blk_o,
    output logic [CC_W-1:0]    cond_o
);

    localparam int MASK_LO = 0;
    localparam int BASE_LO = MASK_LO + MASK_W;

    seq_st_t           st_d, st_q;
    cc_e               eff;
    logic [MASK_W-1:0] mask_nx;
    logic              pass;
    logic              active;
    flags_t            fl;

    assign fl     = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
    assign active = |st_q.mask;

    cbs_slot_ctl u_slot (
        .st_i      (st_q),
        .eff_o     (eff),
        .mask_nx_o (mask_nx)
    );

    cbs_cond_eval u_eval (
        .cc_i   (eff),
        .fl_i   (fl),
        .pass_o (pass)
    );

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            if (instr_i[MASK_LO +: MASK_W] == '0) begin
                st_d = '0;
            end else begin
                st_d.mask  = instr_i[MASK_LO +: MASK_W];
                st_d.base  = instr_i[BASE_LO +: CC_W];
                st_d.first = 1'b1;
            end
        end else if (adv_i && active) begin
            st_d.mask  = mask_nx;
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_blk_o = active;
    assign cond_o   = active ? eff  : CC_AL;
    assign allow_o  = active ? pass : 1'b1;

endmodule

// File: rtl/cbs_chk.sv
module cbs_chk (
    input logic        clk,
    input logic        rst,
    input logic        ld_i,
    input logic [15:0] instr_i,
    input logic        adv_i,
    input logic        allow_o,
    input logic        in_blk_o,
    input logic [3:0]  cond_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !in_blk_o);

    // R2
    load_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_i && instr_i[3:0] != 4'd0) |=> (in_blk_o && cond_o == $past(instr_i[7:4])));

    // R3
    hint_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_i && instr_i[3:0] == 4'd0) |=> !in_blk_o);

    // R7
    idle_allow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_blk_o |-> (allow_o && cond_o == 4'd14));

    // R7
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_blk_o && !ld_i) |=> !in_blk_o);

    // R9
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_blk_o && cond_o == 4'd15) |-> !allow_o);

    // R11
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && !adv_i) |=> ($stable(cond_o) && $stable(in_blk_o)));

endmodule

bind cond_block_seq cbs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (ld_i),
    .instr_i  (instr_i),
    .adv_i    (adv_i),
    .allow_o  (allow_o),
    .in_blk_o (in_blk_o),
    .cond_o   (cond_o)
);

// File: tb/cond_block_seq_tb.sv
module cond_block_seq_tb_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        adv_i = 1'b0;
    logic [3:0]  fl = '0;
    logic        allow_o, in_blk_o;
    logic [3:0]  cond_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    int slots[$];

    always #(PERIOD/2) clk = ~clk;

    cond_block_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .ld_i     (ld_i),
        .instr_i  (instr_i),
        .adv_i    (adv_i),
        .flag_n_i (fl[3]),
        .flag_z_i (fl[2]),
        .flag_c_i (fl[1]),
        .flag_v_i (fl[0]),
        .allow_o  (allow_o),
        .in_blk_o (in_blk_o),
        .cond_o   (cond_o)
    );

    function automatic bit holds(int cc, logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (cc)
            0: return z;            1: return !z;
            2: return c;            3: return !c;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return c && !z;      9: return !c || z;
            10: return n == v;      11: return n != v;
            12: return !z && n == v; 13: return z || n != v;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit l, input logic [15:0] ins, input bit a,
                        input logic [3:0] f, input string tag);
        int ecc;
        @(negedge clk);
        ld_i = l; instr_i = ins; adv_i = a; fl = f;
        #1;
        ecc = (slots.size() == 0) ? 14 : slots[0];
        check(tag, "in_blk", int'(in_blk_o), int'(slots.size() != 0));
        check(tag, "cond", int'(cond_o), ecc);
        check(tag, "allow", int'(allow_o), (slots.size() == 0) ? 1 : int'(holds(ecc, f)));
        @(posedge clk);
        if (l) begin
            slots.delete();
            if (ins[3:0] != 4'd0) begin
                int base = int'(ins[7:4]);
                int low = 0;
                while (ins[low] == 1'b0) low++;
                slots.push_back(base);
                for (int i = 1; i < 4 - low; i++)
                    slots.push_back((base & 14) | int'(ins[4 - i]));
            end
        end else if (a && slots.size() != 0) begin
            void'(slots.pop_front());
        end
    endtask

    function automatic logic [15:0] mk(int cc, int m);
        logic [7:0] hi = 8'($urandom);
        return {hi, 4'(cc), 4'(m)};
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        step(0, '0, 0, 4'b0000, "R1");
        // R7: advances while idle do nothing
        for (int i = 0; i < 8; i++) step(0, 16'($urandom), 1, 4'($urandom), "R7");
        // R8 / R9: every code against every flag set, single-slot runs
        for (int cc = 0; cc < 16; cc++)
            for (int f = 0; f < 16; f++) begin
                step(1, mk(cc, 8), 0, 4'($urandom), (cc == 15) ? "R9" : "R8");
                step(0, '0, 1, 4'(f), (cc == 15) ? "R9" : "R8");
            end
        // R4 / R5 / R6: every mask
        for (int m = 1; m < 16; m++)
            for (int r = 0; r < 3; r++) begin
                step(1, mk(int'($urandom_range(0, 14)), m), 0, 4'($urandom), "R2");
                for (int k = 0; k < 5; k++) step(0, '0, 1, 4'($urandom), (k == 0) ? "R4" : "R5");
                step(0, '0, 0, 4'($urandom), "R6");
            end
        // R3: hint in the middle of a run
        step(1, mk(2, 1), 0, 4'b0010, "R3");
        step(0, '0, 1, 4'b0010, "R3");
        step(1, mk(9, 0), 0, 4'b0100, "R3");
        step(0, '0, 1, 4'b0000, "R3");
        step(1, mk(13, 0), 1, 4'b1001, "R3");
        step(0, '0, 0, 4'b0000, "R3");
        // R10: load and advance together
        step(1, mk(0, 1), 0, 4'b0100, "R10");
        step(0, '0, 1, 4'b0100, "R10");
        step(1, mk(10, 3), 1, 4'b1001, "R10");
        step(0, '0, 0, 4'b1001, "R10");
        step(0, '0, 1, 4'b1000, "R10");
        // R11: hold with varying flags
        step(1, mk(12, 5), 0, 4'b0000, "R11");
        for (int i = 0; i < 10; i++) step(0, 16'($urandom), 0, 4'($urandom), "R11");
        step(0, '0, 1, 4'b0000, "R11");
        for (int i = 0; i < 6; i++) step(0, '0, 0, 4'($urandom), "R11");
        // R2: random traffic
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) == 0, 16'($urandom), $urandom % 2, 4'($urandom), "R2");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule